// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the per-source state for a set of interrupt sources and turns source activity into presentation requests. Each source is fixed at build time as either a message source, which treats a one-cycle high on its input as one event, or a level source, which follows its input level. Every source keeps a destination server, a priority, a saved priority and a few status flags. A request carries the global source number, which is the source index plus a base offset, together with the source's priority and server.

The presentation side answers through three plain notices: a reject or an end-of-interrupt carrying a global number, and a one-cycle resend that makes every source reconsider replaying. A configuration write port sets a source's server, priority and saved priority. A priority of all ones masks a source. Interrupts that are rejected or arrive while masked are kept and replayed later.

Requests leave on one valid/ready port. Back-pressure rules: while `req_valid_o` is high and `req_ready_i` is low, the request stays valid and its number does not change. A request is consumed on a clock edge where both are high. Requests wait in per-source pending bits, so stalling the port loses nothing. Repeated events for one source that is already waiting merge into one request.

Top module: `irqsrc_ctrl`

## Requirements
- R1: Reset clears all status and pending requests and sets every priority and saved priority to all ones (masked). The message or level kind of each source comes only from the parameter `LEVEL_SRC` (bit i set = level) and reset does not change it. Right after reset `req_valid_o` is low.
- R2: A message source whose priority is not all ones and whose input is high in a cycle presents a request in the following cycle with number `BASE_NUM + index`, its priority and its server. Further events while that request waits merge into it.
- R3: A message event while the priority is all ones issues nothing and sets masked-pending. A later configuration write with a priority that is not all ones clears masked-pending and issues one request. A write that keeps the priority at all ones issues nothing.
- R4: A level source issues a request only when its priority is not all ones, its input is high and its sent flag is clear, and it then sets sent. While sent is set, no further request comes from that source.
- R5: A reject of a message source sets its rejected flag and issues nothing. A reject of a level source clears its sent flag and issues nothing.
- R6: On resend, a message source with rejected set clears it and, if unmasked, issues a request. A second resend issues nothing. A level source re-applies its R4 condition.
- R7: An end-of-interrupt clears the sent flag of a level source without issuing a request. For a message source it changes nothing, so a resend that follows issues nothing.
- R8: A configuration write stores server, priority and saved priority, and the stored values appear on later requests. For a level source, the write re-applies the R4 condition.
- R9: A reject or end-of-interrupt whose number lies below `BASE_NUM` or at or above `BASE_NUM + N_SRC` changes no source.
- R10: While `req_valid_o` is high and `req_ready_i` is low, `req_valid_o` stays high and `req_num_o` is unchanged, even if a lower-numbered source becomes pending. Each handshake removes exactly one request.
- R11: With no back-pressure, pending requests leave one per cycle in ascending source index.
- R12: Within one cycle, notices to one source take effect in this order: reject, end-of-interrupt, configuration write, input, resend. So an input event sees the priority written in the same cycle, and a resend sees a reject from the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in_i | input | N_SRC | Source inputs: event pulse (message) or level (level) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Source index written |
| cfg_server_i | input | SRV_W | New destination server |
| cfg_prio_i | input | PRIO_W | New priority (all ones = masked) |
| cfg_saved_prio_i | input | PRIO_W | New saved priority |
| rej_valid_i | input | 1 | Reject notice strobe |
| rej_num_i | input | NUM_W | Global number being rejected |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_num_i | input | NUM_W | Global number being completed |
| resend_i | input | 1 | Global resend pulse |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request ready |
| req_num_o | output | NUM_W | Global source number of the request |
| req_prio_o | output | PRIO_W | Priority of the request |
| req_server_o | output | SRV_W | Destination server of the request |

## Verification
The bench builds the block with eight sources, where sources 0 to 3 are message sources and 4 to 7 are level sources (`LEVEL_SRC = 8'hF0`), and with `BASE_NUM = 16'h1000`. This size lets every source of each kind pass through the full trigger, reject, resend, end-of-interrupt and masking sequences. Expected numbers and priorities are computed from the index. With eight sources, out-of-range numbers just past either end of the window can be reached, and so can a resend scan that releases every message source at once, with their order checked.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;
  typedef enum logic {KIND_MSG = 1'b0, KIND_LVL = 1'b1} src_kind_e;
  localparam int DEF_PRIO_W = 8;
  localparam int DEF_SRV_W  = 8;
  localparam int DEF_NUM_W  = 16;
endpackage

// File: rtl/irqsrc_decode.sv
// Maps a global number onto a one-hot source hit; numbers outside the window hit nothing.
module irqsrc_decode #(
  parameter int N_SRC    = 16,
  parameter int NUM_W    = 16,
  parameter int BASE_NUM = 'h1000
) (
  input  logic             valid_i,
  input  logic [NUM_W-1:0] num_i,
  output logic [N_SRC-1:0] hit_o
);
  localparam int DW = NUM_W + 1;
  logic [DW-1:0] diff;
  logic          in_win;

  assign diff   = {1'b0, num_i} - DW'(BASE_NUM);
  assign in_win = !diff[DW-1] && (diff < DW'(N_SRC));

  for (genvar i = 0; i < N_SRC; i++) begin : g_hit
    assign hit_o[i] = valid_i && in_win && (diff == DW'(i));
  end
endmodule

// File: rtl/irqsrc_slot.sv
// State of one interrupt source; KIND picks the message or level rule set.
module irqsrc_slot
  import irqsrc_pkg::*;
#(
  parameter src_kind_e KIND   = KIND_MSG,
  parameter int        PRIO_W = 8,
  parameter int        SRV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_i,
  input  logic              rej_i,
  input  logic              eoi_i,
  input  logic              cfg_i,
  input  logic [SRV_W-1:0]  cfg_srv_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  input  logic [PRIO_W-1:0] cfg_saved_i,
  input  logic              resend_i,
  input  logic              grant_i,
  output logic              want_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [SRV_W-1:0]  srv_o,
  output logic [PRIO_W-1:0] saved_o
);
  localparam logic [PRIO_W-1:0] MASKED = {PRIO_W{1'b1}};
  localparam bit IS_LVL = (KIND == KIND_LVL);

  logic [PRIO_W-1:0] prio_q, prio_n, saved_q, saved_n;
  logic [SRV_W-1:0]  srv_q, srv_n;
  logic rej_q, rej_n, sent_q, sent_n, asrt_q, asrt_n;
  logic mpend_q, mpend_n, want_q, want_n, eval;

  // Same-cycle order: reject, end-of-interrupt, configuration, input, resend.
  always_comb begin
    prio_n  = prio_q;
    saved_n = saved_q;
    srv_n   = srv_q;
    rej_n   = rej_q;
    sent_n  = sent_q;
    mpend_n = mpend_q;
    asrt_n  = asrt_q;
    want_n  = want_q & ~grant_i;
    eval    = 1'b0;
    if (rej_i) begin
      if (IS_LVL) sent_n = 1'b0;
      else        rej_n  = 1'b1;
    end
    if (eoi_i && IS_LVL) sent_n = 1'b0;
    if (cfg_i) begin
      prio_n  = cfg_prio_i;
      saved_n = cfg_saved_i;
      srv_n   = cfg_srv_i;
      if (IS_LVL) eval = 1'b1;
      else if (mpend_n && (prio_n != MASKED)) begin
        mpend_n = 1'b0;
        want_n  = 1'b1;
      end
    end
    if (IS_LVL) begin
      if (src_i != asrt_q) eval = 1'b1;
      asrt_n = src_i;
    end else if (src_i) begin
      if (prio_n == MASKED) mpend_n = 1'b1;
      else                  want_n  = 1'b1;
    end
    if (resend_i) begin
      if (IS_LVL) eval = 1'b1;
      else if (rej_n) begin
        rej_n = 1'b0;
        if (prio_n != MASKED) want_n = 1'b1;
      end
    end
    if (IS_LVL && eval && (prio_n != MASKED) && asrt_n && !sent_n) begin
      sent_n = 1'b1;
      want_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q  <= MASKED;
      saved_q <= MASKED;
      srv_q   <= '0;
      rej_q   <= 1'b0;
      sent_q  <= 1'b0;
      asrt_q  <= 1'b0;
      mpend_q <= 1'b0;
      want_q  <= 1'b0;
    end else begin
      prio_q  <= prio_n;
      saved_q <= saved_n;
      srv_q   <= srv_n;
      rej_q   <= rej_n;
      sent_q  <= sent_n;
      asrt_q  <= asrt_n;
      mpend_q <= mpend_n;
      want_q  <= want_n;
    end
  end

  assign want_o  = want_q;
  assign prio_o  = prio_q;
  assign srv_o   = srv_q;
  assign saved_o = saved_q;
endmodule

// File: rtl/irqsrc_pick.sv
// Lowest-index picker that holds its choice while the output is stalled.
module irqsrc_pick #(
  parameter int N_SRC = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] want_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] first, lock_idx;
  logic             locked;

  always_comb begin
    first = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (want_i[i]) first = IDX_W'(i);
    end
  end

  assign valid_o = |want_i;
  assign idx_o   = locked ? lock_idx : first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      lock_idx <= '0;
    end else begin
      locked   <= valid_o && !ready_i;
      lock_idx <= idx_o;
    end
  end
endmodule

// File: rtl/irqsrc_ctrl.sv
module irqsrc_ctrl
  import irqsrc_pkg::*;
#(
  parameter int               N_SRC     = 16,
  parameter int               IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  parameter int               NUM_W     = DEF_NUM_W,
  parameter int               PRIO_W    = DEF_PRIO_W,
  parameter int               SRV_W     = DEF_SRV_W,
  parameter int               BASE_NUM  = 'h1000,
  parameter logic [N_SRC-1:0] LEVEL_SRC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_in_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [SRV_W-1:0]  cfg_server_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  input  logic [PRIO_W-1:0] cfg_saved_prio_i,
  input  logic              rej_valid_i,
  input  logic [NUM_W-1:0]  rej_num_i,
  input  logic              eoi_valid_i,
  input  logic [NUM_W-1:0]  eoi_num_i,
  input  logic              resend_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [NUM_W-1:0]  req_num_o,
  output logic [PRIO_W-1:0] req_prio_o,
  output logic [SRV_W-1:0]  req_server_o
);
  logic [N_SRC-1:0]        rej_hit, eoi_hit, cfg_hit, grant, want;
  logic [PRIO_W-1:0]       prio_arr [N_SRC];
  logic [SRV_W-1:0]        srv_arr  [N_SRC];
  logic [N_SRC*PRIO_W-1:0] saved_flat;
  logic [IDX_W-1:0]        pick_idx;

  irqsrc_decode #(.N_SRC(N_SRC), .NUM_W(NUM_W), .BASE_NUM(BASE_NUM)) u_rej_dec (
    .valid_i(rej_valid_i), .num_i(rej_num_i), .hit_o(rej_hit));

  irqsrc_decode #(.N_SRC(N_SRC), .NUM_W(NUM_W), .BASE_NUM(BASE_NUM)) u_eoi_dec (
    .valid_i(eoi_valid_i), .num_i(eoi_num_i), .hit_o(eoi_hit));

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign cfg_hit[i] = cfg_we_i && (cfg_idx_i == IDX_W'(i));
    assign grant[i]   = req_valid_o && req_ready_i && (pick_idx == IDX_W'(i));

    irqsrc_slot #(
      .KIND  (LEVEL_SRC[i] ? KIND_LVL : KIND_MSG),
      .PRIO_W(PRIO_W),
      .SRV_W (SRV_W)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src_in_i[i]),
      .rej_i      (rej_hit[i]),
      .eoi_i      (eoi_hit[i]),
      .cfg_i      (cfg_hit[i]),
      .cfg_srv_i  (cfg_server_i),
      .cfg_prio_i (cfg_prio_i),
      .cfg_saved_i(cfg_saved_prio_i),
      .resend_i   (resend_i),
      .grant_i    (grant[i]),
      .want_o     (want[i]),
      .prio_o     (prio_arr[i]),
      .srv_o      (srv_arr[i]),
      .saved_o    (saved_flat[i*PRIO_W +: PRIO_W])
    );
  end

  irqsrc_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .want_i (want),
    .ready_i(req_ready_i),
    .valid_o(req_valid_o),
    .idx_o  (pick_idx)
  );

  assign req_num_o    = NUM_W'(BASE_NUM) + NUM_W'(pick_idx);
  assign req_prio_o   = prio_arr[pick_idx];
  assign req_server_o = srv_arr[pick_idx];
endmodule

// File: rtl/irqsrc_ctrl_chk.sv
module irqsrc_ctrl_chk #(
  parameter int N_SRC    = 16,
  parameter int IDX_W    = 4,
  parameter int NUM_W    = 16,
  parameter int PRIO_W   = 8,
  parameter int BASE_NUM = 'h1000
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_SRC-1:0]        src_in_i,
  input logic                    cfg_we_i,
  input logic [IDX_W-1:0]        cfg_idx_i,
  input logic [PRIO_W-1:0]       cfg_saved_prio_i,
  input logic                    resend_i,
  input logic                    req_valid_o,
  input logic                    req_ready_i,
  input logic [NUM_W-1:0]        req_num_o,
  input logic [N_SRC*PRIO_W-1:0] saved_flat
);
  logic [IDX_W-1:0]  wr_idx_q;
  logic [PRIO_W-1:0] wr_val_q;
  logic              quiet;

  always_ff @(posedge clk) begin
    wr_idx_q <= cfg_idx_i;
    wr_val_q <= cfg_saved_prio_i;
  end

  assign quiet = !cfg_we_i && !resend_i && (src_in_i == '0);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !req_valid_o);

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_num_o));

  a_r2_num_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_num_o >= NUM_W'(BASE_NUM)) &&
                    (req_num_o < NUM_W'(BASE_NUM + N_SRC)));

  a_r11_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && ($past(src_in_i) == '0) && req_valid_o && req_ready_i
      |=> !req_valid_o || (req_num_o > $past(req_num_o)));

  a_r8_saved_written: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i && (int'(cfg_idx_i) < N_SRC)
      |=> saved_flat[wr_idx_q*PRIO_W +: PRIO_W] == wr_val_q);
endmodule

bind irqsrc_ctrl irqsrc_ctrl_chk #(
  .N_SRC(N_SRC), .IDX_W(IDX_W), .NUM_W(NUM_W), .PRIO_W(PRIO_W), .BASE_NUM(BASE_NUM)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .src_in_i        (src_in_i),
  .cfg_we_i        (cfg_we_i),
  .cfg_idx_i       (cfg_idx_i),
  .cfg_saved_prio_i(cfg_saved_prio_i),
  .resend_i        (resend_i),
  .req_valid_o     (req_valid_o),
  .req_ready_i     (req_ready_i),
  .req_num_o       (req_num_o),
  .saved_flat      (saved_flat)
);

// File: tb/tb_irqsrc_ctrl.sv
`timescale 1ns/1ps
module tb_irqsrc_ctrl;
  localparam int N    = 8;
  localparam int IW   = 3;
  localparam int BASE = 'h1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_in = '0;
  logic cfg_we = 0, rej_v = 0, eoi_v = 0, resend = 0, ready = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [7:0] cfg_srv = '0, cfg_prio = '0, cfg_saved = '0;
  logic [15:0] rej_num = '0, eoi_num = '0;
  logic req_valid;
  logic [15:0] req_num;
  logic [7:0] req_prio, req_srv;
  logic [7:0] exp_prio [N];
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irqsrc_ctrl #(.N_SRC(N), .NUM_W(16), .PRIO_W(8), .SRV_W(8), .BASE_NUM(BASE),
                .LEVEL_SRC(8'hF0)) dut (
    .clk(clk), .rst_n(rst_n), .src_in_i(src_in), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_server_i(cfg_srv), .cfg_prio_i(cfg_prio), .cfg_saved_prio_i(cfg_saved),
    .rej_valid_i(rej_v), .rej_num_i(rej_num), .eoi_valid_i(eoi_v), .eoi_num_i(eoi_num),
    .resend_i(resend), .req_valid_o(req_valid), .req_ready_i(ready), .req_num_o(req_num),
    .req_prio_o(req_prio), .req_server_o(req_srv));

  task automatic step(); @(negedge clk); endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(int i, logic [7:0] p);
    cfg_we = 1; cfg_idx = IW'(i); cfg_srv = 8'h40 + 8'(i); cfg_prio = p; cfg_saved = p ^ 8'h0F;
    exp_prio[i] = p;
    step(); cfg_we = 0;
  endtask

  task automatic pulse(int i); src_in[i] = 1; step(); src_in[i] = 0; endtask
  task automatic reject(int n); rej_v = 1; rej_num = 16'(n); step(); rej_v = 0; endtask
  task automatic eoi(int n); eoi_v = 1; eoi_num = 16'(n); step(); eoi_v = 0; endtask
  task automatic do_resend(); resend = 1; step(); resend = 0; endtask

  task automatic expect_req(string tag, int i);
    chk({tag, " valid"}, 32'(req_valid), 1);
    chk({tag, " num"}, 32'(req_num), 32'(BASE + i));
    chk({tag, " prio"}, 32'(req_prio), 32'(exp_prio[i]));
    chk({tag, " server"}, 32'(req_srv), 32'(8'h40 + i));
    ready = 1; step(); ready = 0;
  endtask

  task automatic expect_none(string tag);
    chk({tag, " idle"}, 32'(req_valid), 0);
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step(); rst_n = 1; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step();
    do_reset();
    // R1: idle and masked after reset
    expect_none("R1 reset");
    pulse(1); expect_none("R1 masked msg");
    src_in[5] = 1; step(); expect_none("R1 masked lvl");
    src_in[5] = 0; step();
    do_reset();
    expect_none("R1 cleared pending");

    for (int i = 0; i < 4; i++) begin
      cfg(i, 8'(i + 1));
      pulse(i); expect_req("R2 msg", i); expect_none("R2 single");
      pulse(i); pulse(i); expect_req("R2 merged", i); expect_none("R2 merged once");
      reject(BASE + i); expect_none("R5 msg reject");
      do_resend(); expect_req("R6 replay", i);
      do_resend(); expect_none("R6 rejected cleared");
      pulse(i); expect_req("R7 msg", i);
      eoi(BASE + i); do_resend(); expect_none("R7 msg eoi no effect");
      cfg(i, 8'hFF); pulse(i); expect_none("R3 masked");
      cfg(i, 8'hFF); expect_none("R3 still masked");
      cfg(i, 8'(i + 2)); expect_req("R3 released", i); expect_none("R3 once");
    end

    for (int j = 4; j < 8; j++) begin
      cfg(j, 8'(j + 1));
      src_in[j] = 1; step(); expect_req("R4 lvl", j); expect_none("R4 sent");
      reject(BASE + j); expect_none("R5 lvl reject");
      do_resend(); expect_req("R6 lvl replay", j);
      eoi(BASE + j); expect_none("R7 lvl eoi");
      do_resend(); expect_req("R7 lvl after eoi", j);
      reject(BASE + j); cfg(j, 8'(j + 3)); expect_req("R8 lvl reeval", j);
      src_in[j] = 0; step(); eoi(BASE + j); cfg(j, 8'(j + 3));
      expect_none("R4 deasserted");
      cfg(j, 8'hFF); src_in[j] = 1; step(); expect_none("R4 masked lvl");
      cfg(j, 8'(j + 1)); expect_req("R8 unmask lvl", j);
      src_in[j] = 0; step(); eoi(BASE + j);
    end

    // R9: out-of-window numbers
    pulse(1); expect_req("R9 setup", 1);
    reject(BASE + N); reject(BASE - 1); reject(1); do_resend();
    expect_none("R9 reject ignored");
    reject(BASE + 1); do_resend(); expect_req("R9 in range", 1);
    src_in[6] = 1; step(); expect_req("R9 lvl setup", 6);
    eoi(BASE + N + 6); eoi(BASE - 2); do_resend(); expect_none("R9 eoi ignored");
    src_in[6] = 0; step(); eoi(BASE + 6);

    // R10: stall holds the chosen request
    pulse(2);
    for (int k = 0; k < 3; k++) begin
      chk("R10 held valid", 32'(req_valid), 1);
      chk("R10 held num", 32'(req_num), 32'(BASE + 2));
      step();
    end
    pulse(0);
    chk("R10 no preempt", 32'(req_num), 32'(BASE + 2));
    expect_req("R10 first", 2); expect_req("R10 second", 0); expect_none("R10 drained");

    // R11: ascending replay
    for (int i = 0; i < 4; i++) begin pulse(i); expect_req("R11 setup", i); end
    for (int i = 3; i >= 0; i--) reject(BASE + i);
    do_resend();
    for (int i = 0; i < 4; i++) expect_req("R11 order", i);
    expect_none("R11 drained");

    // R12: same-cycle ordering
    cfg(3, 8'hFF);
    cfg_we = 1; cfg_idx = 3'd3; cfg_srv = 8'h43; cfg_prio = 8'd6; cfg_saved = 8'd6;
    src_in[3] = 1; exp_prio[3] = 8'd6;
    step(); cfg_we = 0; src_in[3] = 0;
    expect_req("R12 cfg before input", 3); expect_none("R12 no pending");
    pulse(2); expect_req("R12 setup", 2);
    rej_v = 1; rej_num = 16'(BASE + 2); resend = 1; step(); rej_v = 0; resend = 0;
    expect_req("R12 reject before resend", 2);

    // R1: reset clears rejected and keeps kinds
    pulse(1); expect_req("R1 setup", 1); reject(BASE + 1);
    do_reset();
    cfg(1, 8'd3); do_resend(); expect_none("R1 rejected cleared");
    cfg(5, 8'd4); src_in[5] = 1; step(); expect_req("R1 kind kept", 5);
    expect_none("R1 level still level");
    src_in[5] = 0; step();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule